// File: doc/BRIEF.md
# Bit-Clock Ratio Validator

This block checks that the serial-audio bit clock runs at a legal multiple of the sample rate. The bit clock and the word-select line come in asynchronously. Both are resynchronised into the system clock domain, and their rising edges are detected there. Bit-clock rising edges are counted across each full word-select period, from one word-select rising edge to the next. The count is then compared against the three legal ratios: 32, 48 and 64 bit clocks per frame.

A ratio is accepted only when two frames in a row give the same legal count. When a ratio is accepted, the block does four things:
- it reports the ratio as a 2-bit code;
- it raises a valid flag;
- it enables the power-stage outputs;
- it releases the clock-source override, so the master clock may be derived from the bit clock.

The block withdraws its approval in any of these cases:
- a frame has an illegal count;
- the separate master-clock health input goes low;
- word-select stops toggling for a programmable number of system cycles.

When approval is withdrawn, the outputs fall back to the high-impedance request and the override is asserted again. The master-clock health input is expected to be synchronous to the system clock.

Top module: `bck_ratio_check`

## Requirements
- R1: While reset is high and after it is released, ratio_code is 2'b00, ratio_valid and out_enable are 0 and clk_src_override is 1.
- R2: A frame is the span between two word-select rising edges, and its length is the number of bit-clock rising edges inside it. The first word-select rising edge after reset only starts measurement and produces no verdict.
- R3: The legal frame lengths and their codes are: 32 gives 2'b01, 48 gives 2'b10 and 64 gives 2'b11. Every other length maps to 2'b00. While ratio_valid is 1, ratio_code carries the confirmed code; otherwise it is 2'b00.
- R4: ratio_valid rises only at the end of a frame whose legal length equals that of the frame just before it. A legal frame whose length differs from the preceding one leaves ratio_valid at 0.
- R5: A frame with an illegal length clears ratio_valid and out_enable and sets clk_src_override when that frame ends. The history is also cleared, so two further matching frames are needed before ratio_valid rises again.
- R6: The frame length counter saturates at 127. A frame of more than 127 bit clocks (for example 160) is illegal and never aliases to a legal length.
- R7: While mclk_ok is 0, ratio_valid and out_enable are 0 and clk_src_override is 1 from the next cycle on, and the history is cleared.
- R8: If no word-select rising edge is seen for timeout_cycles system cycles (when timeout_cycles is non-zero), the block declares the input invalid and clears the history. Before that limit is reached, a confirmed ratio stays valid.
- R9: out_enable always equals ratio_valid, and clk_src_override is always its inverse. All four outputs are registered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst | input | 1 | Synchronous active-high reset |
| bck_in | input | 1 | Asynchronous serial bit clock |
| ws_in | input | 1 | Asynchronous word-select (frame) signal |
| mclk_ok | input | 1 | Master-clock health, 1 = healthy, system-clock synchronous |
| timeout_cycles | input | TO_W | Word-select silence limit in system cycles, 0 disables it |
| ratio_code | output | 2 | 00 invalid, 01 = 32x, 10 = 48x, 11 = 64x |
| ratio_valid | output | 1 | A legal ratio is confirmed |
| out_enable | output | 1 | Power-stage enable; 0 requests high impedance |
| clk_src_override | output | 1 | 1 forbids deriving the master clock from the bit clock |

## Verification
The verdict on a frame appears four system cycles after the word-select rising edge that closes it. Two of those cycles are spent in the synchronizer, one in the edge/frame register and one in the judge register. A master-clock drop shows at the outputs one cycle after mclk_ok falls. A timeout shows one cycle after the silence counter reaches timeout_cycles.

The bench driver pushes the expected outputs for the preceding frame twelve cycles after each word-select rise, well past the four-cycle latency and before the next verdict can arrive. The monitor compares the outputs on the falling edge. For the master-clock and timeout cases, expectations are pushed only after several cycles, and well before or after the silence limit, never at the limit itself.

// File: rtl/bck_ratio_pkg.sv
package bck_ratio_pkg;
  typedef enum logic [1:0] {
    RATIO_NONE = 2'b00,
    RATIO_32   = 2'b01,
    RATIO_48   = 2'b10,
    RATIO_64   = 2'b11
  } ratio_e;
endpackage

// File: rtl/sync_rise.sv
module sync_rise #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
      prev  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], din};
      prev  <= chain[STAGES-1];
    end
  end

  assign rise = chain[STAGES-1] & ~prev;
endmodule

// File: rtl/frame_counter.sv
module frame_counter #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bck_rise,
  input  logic             ws_rise,
  output logic             frame_done,
  output logic [CNT_W-1:0] frame_cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt;
  logic             armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt        <= '0;
      armed      <= 1'b0;
      frame_done <= 1'b0;
      frame_cnt  <= '0;
    end else begin
      frame_done <= 1'b0;
      if (ws_rise) begin
        armed <= 1'b1;
        if (armed) begin
          frame_done <= 1'b1;
          frame_cnt  <= cnt;
        end
        cnt <= bck_rise ? CNT_W'(1) : '0;
      end else if (bck_rise && cnt != CNT_MAX) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R6: a full counter stays full until the frame closes
  p_count_saturates_r6: assert property (@(posedge clk) disable iff (rst)
    (bck_rise && !ws_rise && cnt == CNT_MAX) |=> cnt == CNT_MAX);

  // R2: a frame closes in a single-cycle pulse
  p_done_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> !frame_done);
endmodule

// File: rtl/ratio_judge.sv
module ratio_judge
  import bck_ratio_pkg::*;
#(
  parameter int CNT_W = 7,
  parameter int TO_W  = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_done,
  input  logic [CNT_W-1:0] frame_cnt,
  input  logic             ws_rise,
  input  logic             mclk_ok,
  input  logic [TO_W-1:0]  timeout_cycles,
  output logic [1:0]       ratio_code,
  output logic             ratio_valid,
  output logic             out_enable,
  output logic             clk_src_override
);
  localparam logic [TO_W-1:0] TO_MAX = {TO_W{1'b1}};

  function automatic ratio_e classify(input logic [CNT_W-1:0] n);
    if (n == CNT_W'(32))      return RATIO_32;
    else if (n == CNT_W'(48)) return RATIO_48;
    else if (n == CNT_W'(64)) return RATIO_64;
    else                      return RATIO_NONE;
  endfunction

  logic [TO_W-1:0] silence;
  logic            timed_out;
  ratio_e          fresh;
  ratio_e          hist;
  ratio_e          code_q;

  assign fresh     = classify(frame_cnt);
  assign timed_out = (timeout_cycles != '0) && (silence >= timeout_cycles);

  always_ff @(posedge clk) begin
    if (rst || ws_rise)          silence <= '0;
    else if (silence != TO_MAX)  silence <= silence + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || !mclk_ok || timed_out) begin
      hist             <= RATIO_NONE;
      code_q           <= RATIO_NONE;
      ratio_valid      <= 1'b0;
      out_enable       <= 1'b0;
      clk_src_override <= 1'b1;
    end else if (frame_done) begin
      hist <= fresh;
      if (fresh != RATIO_NONE && fresh == hist) begin
        code_q           <= fresh;
        ratio_valid      <= 1'b1;
        out_enable       <= 1'b1;
        clk_src_override <= 1'b0;
      end else begin
        code_q           <= RATIO_NONE;
        ratio_valid      <= 1'b0;
        out_enable       <= 1'b0;
        clk_src_override <= 1'b1;
      end
    end
  end

  assign ratio_code = code_q;

  // R5: an illegal frame drops approval on the next cycle
  p_illegal_drops_r5: assert property (@(posedge clk) disable iff (rst)
    (frame_done && fresh == RATIO_NONE) |=> !ratio_valid);

  // R7: an unhealthy master clock forces the safe state
  p_mclk_drop_r7: assert property (@(posedge clk) disable iff (rst)
    !mclk_ok |=> (!ratio_valid && !out_enable && clk_src_override));

  // R8: word-select silence forces invalid
  p_timeout_r8: assert property (@(posedge clk) disable iff (rst)
    timed_out |=> !ratio_valid);

  // R4: approval only ever begins at a frame boundary
  p_rise_on_frame_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(ratio_valid) |-> $past(frame_done));
endmodule

// File: rtl/bck_ratio_check.sv
module bck_ratio_check #(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 7,
  parameter int TO_W        = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bck_in,
  input  logic            ws_in,
  input  logic            mclk_ok,
  input  logic [TO_W-1:0] timeout_cycles,
  output logic [1:0]      ratio_code,
  output logic            ratio_valid,
  output logic            out_enable,
  output logic            clk_src_override
);
  logic             bck_rise;
  logic             ws_rise;
  logic             frame_done;
  logic [CNT_W-1:0] frame_cnt;

  sync_rise #(.STAGES(SYNC_STAGES)) u_bck_sync (
    .clk(clk), .rst(rst), .din(bck_in), .rise(bck_rise)
  );

  sync_rise #(.STAGES(SYNC_STAGES)) u_ws_sync (
    .clk(clk), .rst(rst), .din(ws_in), .rise(ws_rise)
  );

  frame_counter #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst(rst), .bck_rise(bck_rise), .ws_rise(ws_rise),
    .frame_done(frame_done), .frame_cnt(frame_cnt)
  );

  ratio_judge #(.CNT_W(CNT_W), .TO_W(TO_W)) u_judge (
    .clk(clk), .rst(rst), .frame_done(frame_done), .frame_cnt(frame_cnt),
    .ws_rise(ws_rise), .mclk_ok(mclk_ok), .timeout_cycles(timeout_cycles),
    .ratio_code(ratio_code), .ratio_valid(ratio_valid),
    .out_enable(out_enable), .clk_src_override(clk_src_override)
  );
endmodule

// File: tb/sim_bck_ratio_check.sv
module sim_bck_ratio_check;
  localparam int TO_W = 16;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            bck = 1'b1;
  logic            ws  = 1'b0;
  logic            mclk_ok = 1'b1;
  logic [TO_W-1:0] timeout_cycles = TO_W'(1000);
  logic [1:0]      ratio_code;
  logic            ratio_valid;
  logic            out_enable;
  logic            clk_src_override;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  typedef struct {
    logic       ev;
    logic [1:0] ec;
    string      req;
  } exp_t;
  exp_t q[$];

  always #2 clk = ~clk;

  bck_ratio_check #(.TO_W(TO_W)) u0 (
    .clk(clk), .rst(rst), .bck_in(bck), .ws_in(ws), .mclk_ok(mclk_ok),
    .timeout_cycles(timeout_cycles), .ratio_code(ratio_code),
    .ratio_valid(ratio_valid), .out_enable(out_enable),
    .clk_src_override(clk_src_override)
  );

  task automatic expect_now(input logic ev, input logic [1:0] ec, input string req);
    exp_t e;
    e.ev = ev; e.ec = ec; e.req = req;
    q.push_back(e);
  endtask

  // one frame of n bit clocks; 12 cycles after its opening word-select edge
  // the expectation for the frame it closes is queued
  task automatic send_frame(input int n, input logic ev, input logic [1:0] ec,
                            input string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bck = 1'b0;
      if (i == 0) ws = 1'b1;
      else if (i == n / 2) ws = 1'b0;
      if (i == 3) expect_now(ev, ec, req);
      @(negedge clk);
      @(negedge clk);
      bck = 1'b1;
      @(negedge clk);
    end
  endtask

  // monitor: scoreboard pop and compare
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        total++;
        if (ratio_valid !== e.ev || ratio_code !== e.ec ||
            out_enable !== e.ev || clk_src_override !== !e.ev) begin
          bad++;
          $display("FAIL %s: valid=%b code=%b oe=%b ovr=%b expected valid=%b code=%b oe=%b ovr=%b",
                   e.req, ratio_valid, ratio_code, out_enable, clk_src_override,
                   e.ev, e.ec, e.ev, !e.ev);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    expect_now(1'b0, 2'b00, "R1");           // during reset
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    expect_now(1'b0, 2'b00, "R1");           // after release
    send_frame(32, 1'b0, 2'b00, "R2");        // first edge only arms
    send_frame(32, 1'b0, 2'b00, "R4");        // one legal frame is not enough
    send_frame(32, 1'b1, 2'b01, "R3");        // 32 confirmed
    send_frame(48, 1'b1, 2'b01, "R4");
    send_frame(48, 1'b0, 2'b00, "R4");        // length changed
    send_frame(64, 1'b1, 2'b10, "R3");        // 48 confirmed
    send_frame(64, 1'b0, 2'b00, "R4");
    send_frame(40, 1'b1, 2'b11, "R3");        // 64 confirmed
    send_frame(64, 1'b0, 2'b00, "R5");        // 40 is illegal
    send_frame(64, 1'b0, 2'b00, "R5");        // history was cleared
    send_frame(64, 1'b1, 2'b11, "R5");
    mclk_ok = 1'b0;
    repeat (3) @(negedge clk);
    expect_now(1'b0, 2'b00, "R7");
    repeat (2) @(negedge clk);
    mclk_ok = 1'b1;
    repeat (2) @(negedge clk);
    send_frame(64, 1'b0, 2'b00, "R7");        // history lost during drop
    send_frame(64, 1'b1, 2'b11, "R7");
    send_frame(32, 1'b1, 2'b11, "R9");
    send_frame(32, 1'b0, 2'b00, "R4");
    send_frame(160, 1'b1, 2'b01, "R6");
    send_frame(32, 1'b0, 2'b00, "R6");        // 160 must not alias to 32
    send_frame(32, 1'b0, 2'b00, "R6");
    send_frame(32, 1'b1, 2'b01, "R3");
    repeat (700) @(negedge clk);
    expect_now(1'b1, 2'b01, "R8");            // below the silence limit
    repeat (300) @(negedge clk);
    expect_now(1'b0, 2'b00, "R8");            // past the limit
    send_frame(64, 1'b0, 2'b00, "R8");
    send_frame(64, 1'b0, 2'b00, "R8");
    send_frame(64, 1'b1, 2'b11, "R8");
    repeat (20) @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule